// File: doc/BRIEF.md
# Gated Two-Stage Card Clock Divider

This block turns a fast source clock into the clock for a storage-card interface. The division is made by two cascaded stages. A power-of-two pre-divider (factor 1, 2, 4, 8 or 16) produces one tick every P source cycles. A final stage then counts F of those ticks, with F equal to 2 or 4. The card clock therefore has a period of N = P × F source cycles, from 2 to 64, and is high for the first N/2 cycles of each period.

The block has two outputs. The card clock and a host-side clock share the same divided waveform, and each one has its own stop bit. Software programs a 10-bit control word through a plain write strobe and reads it back at any time.

Every change is applied only at the end of an output period, while the waveform is low. This covers the ratio, both stop bits and the quiet state forced by an unsupported code. Because of this the outputs never show a runt pulse or a shortened cycle.

Top module: `sdclk_gen`

## Requirements
- R1: A cycle with `wr_en` high stores `wr_data[9:0]`. From the next cycle, `rd_data` returns that value in bits 9:0, and bits 31:10 read as zero.
- R2: After reset the control word is 0x301. This selects pre-divider code 0 and final code 1 (divide by 4) with both clocks stopped, and `card_clk` and `host_clk` stay low.
- R3: Control bits 4:2 are the pre-divider code. Codes 0..4 give factors 1, 2, 4, 8 and 16. Control bits 1:0 are the final code: 1 divides by 4 and 0 divides by 2. With a valid word in force, each output has a period of N = pre factor × final factor source cycles and is high for N/2 of them.
- R4: Bit 8 set to 1 holds `card_clk` low from the next period boundary, while `host_clk` keeps running if bit 9 is 0.
- R5: Bit 9 set to 1 holds `host_clk` low from the next period boundary, while `card_clk` keeps running if bit 8 is 0.
- R6: A pre-divider code above 4, or a final code of 2 or 3, raises `cfg_invalid` one cycle after the write. From the next period boundary it holds both clocks low. A later valid write clears the flag.
- R7: `clk_enabled` is high only when bits 9 and 8 are both 0 and the stored word is valid.
- R8: A new ratio or stop setting takes effect only at a period boundary. Rising output edges occur only at the start of a period, and every high or low phase lasts the full half period of either the old or the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data; only bits 9:0 are kept |
| rd_data | output | 32 | Stored control word, upper bits zero |
| card_clk | output | 1 | Divided, gated card clock |
| host_clk | output | 1 | Divided, gated host-side clock |
| cfg_invalid | output | 1 | Stored word holds an unsupported code |
| clk_enabled | output | 1 | Both clocks requested on with a valid word |

## Verification
The read-back value, `cfg_invalid` and `clk_enabled` are due one cycle after the write edge, and the bench samples them at the following falling edge. Clock-output changes are due only at the next period boundary, which can be up to 64 source cycles later. For this reason the bench waits 140 cycles after each write before it measures the high and low phases edge to edge, and it looks for stuck-low outputs over a window longer than the longest period. The ratio-change checks write in the middle of a high phase. They then require every following phase to match one of the two half periods, with the last one matching the new ratio.

// File: rtl/sdclk_pkg.sv
// Shared field positions, widths and the decoded-configuration type for the
// card clock divider. Assumes a 10-bit control field inside a 32-bit word.
package sdclk_pkg;
    localparam int CTL_W        = 32;               // software word width
    localparam int FLD_W        = 10;               // implemented control bits
    localparam int PRE_W        = 3;                // pre-divider code width
    localparam int PRE_LSB      = 2;                // pre-divider code position
    localparam int FIN_W        = 2;                // final-stage code / counter width
    localparam int STOP_CARD    = 8;                // card clock stop bit
    localparam int STOP_HOST    = 9;                // host-side clock stop bit
    localparam int PRE_MAX_CODE = 4;                // largest legal pre-divider code
    localparam int PRE_CNT_W    = PRE_MAX_CODE;     // holds 2**PRE_MAX_CODE - 1
    localparam logic [FLD_W-1:0] CTL_RESET = 10'h301;

    typedef struct packed {
        logic             valid;
        logic             stop_host;
        logic             stop_card;
        logic [PRE_W-1:0] pre_code;
        logic             fin_by4;
    } div_cfg_t;
endpackage

// File: rtl/sdclk_cfg_reg.sv
// Control register and field decode. Stores the low control bits on a write
// strobe, returns them zero-extended, and flags unsupported codes.
// Assumes one write per cycle at most; no byte enables.
module sdclk_cfg_reg
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output div_cfg_t         cfg
);
    logic [FLD_W-1:0] ctl_q;
    logic             unused_hi;

    // store the implemented control bits
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= CTL_RESET;
        else if (wr_en) ctl_q <= wr_data[FLD_W-1:0];
    end

    assign unused_hi = ^wr_data[CTL_W-1:FLD_W];

    // zero-extended read path
    assign rd_data = {{(CTL_W-FLD_W){1'b0}}, ctl_q};

    // decode fields and legality
    always_comb begin
        cfg.stop_host = ctl_q[STOP_HOST];
        cfg.stop_card = ctl_q[STOP_CARD];
        cfg.pre_code  = ctl_q[PRE_LSB +: PRE_W];
        cfg.fin_by4   = ctl_q[0];
        cfg.valid     = (ctl_q[PRE_LSB +: PRE_W] <= PRE_W'(PRE_MAX_CODE)) && !ctl_q[1];
    end

    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {{(CTL_W-FLD_W){1'b0}}, $past(wr_data[FLD_W-1:0])});
endmodule

// File: rtl/sdclk_prescale.sv
// First divider stage: emits a one-cycle tick every 2**code source cycles.
// Assumes code only changes on the cycle after a tick (period boundary),
// so the count always restarts from zero with the new factor.
module sdclk_prescale #(
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // terminal count for the selected power-of-two factor
    always_comb limit = (CNT_W'(1) << code) - CNT_W'(1);
    assign tick = (cnt_q == limit);

    // free-running count that wraps on the tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end

    a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/sdclk_final_stage.sv
// Second divider stage plus output gating. Counts prescaler ticks up to 2 or 4,
// holds the ratio and stop state in force, and loads the requested ones only
// at a period boundary, when the divided waveform is low. Outputs are flops.
module sdclk_final_stage
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  div_cfg_t         req,
    output logic [PRE_W-1:0] app_pre,
    output logic             card_clk,
    output logic             host_clk
);
    logic             by4_q, by4_n;
    logic [PRE_W-1:0] pre_q, pre_n;
    logic             card_run_q, card_run_n;
    logic             host_run_q, host_run_n;
    logic [FIN_W-1:0] fin_q, fin_n, last, half_n;
    logic             bnd, level_n;

    // next state: advance on tick, reload settings at the boundary
    always_comb begin
        last       = by4_q ? FIN_W'(3) : FIN_W'(1);
        bnd        = tick && (fin_q == last);
        fin_n      = fin_q;
        pre_n      = pre_q;
        by4_n      = by4_q;
        card_run_n = card_run_q;
        host_run_n = host_run_q;
        if (tick) fin_n = bnd ? '0 : fin_q + FIN_W'(1);
        if (bnd) begin
            card_run_n = req.valid && !req.stop_card;
            host_run_n = req.valid && !req.stop_host;
            if (req.valid) begin
                pre_n = req.pre_code;
                by4_n = req.fin_by4;
            end
        end
        half_n  = by4_n ? FIN_W'(2) : FIN_W'(1);
        level_n = (fin_n < half_n);
    end

    // state and registered, gated outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q      <= '0;
            pre_q      <= '0;
            by4_q      <= 1'b1;
            card_run_q <= 1'b0;
            host_run_q <= 1'b0;
            card_clk   <= 1'b0;
            host_clk   <= 1'b0;
        end else begin
            fin_q      <= fin_n;
            pre_q      <= pre_n;
            by4_q      <= by4_n;
            card_run_q <= card_run_n;
            host_run_q <= host_run_n;
            card_clk   <= card_run_n && level_n;
            host_clk   <= host_run_n && level_n;
        end
    end

    assign app_pre = pre_q;

    a_r3_fin_range: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q <= (by4_q ? FIN_W'(3) : FIN_W'(1)));
    a_r4_card_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && req.stop_card) |=> !card_clk);
    a_r5_host_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && req.stop_host) |=> !host_clk);
    a_r6_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && !req.valid) |=> (!card_clk && !host_clk));
    a_r8_gate_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (card_run_q != $past(card_run_q)) |-> !$past(card_clk));
    a_r8_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> (fin_q == '0));
endmodule

// File: rtl/sdclk_gen.sv
// Top of the gated two-stage card clock divider: control register, power-of-two
// prescaler and final 2/4 stage with independent card and host stop gating.
// Assumes all logic runs on the source clock with a synchronous reset.
module sdclk_gen
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    output logic             card_clk,
    output logic             host_clk,
    output logic             cfg_invalid,
    output logic             clk_enabled
);
    div_cfg_t         cfg;
    logic [PRE_W-1:0] app_pre;
    logic             tick;

    sdclk_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    sdclk_prescale #(.CODE_W(PRE_W), .CNT_W(PRE_CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (app_pre),
        .tick  (tick)
    );

    sdclk_final_stage u_fin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .req      (cfg),
        .app_pre  (app_pre),
        .card_clk (card_clk),
        .host_clk (host_clk)
    );

    // status derived from the stored word
    assign cfg_invalid = !cfg.valid;
    assign clk_enabled = cfg.valid && !cfg.stop_card && !cfg.stop_host;

    a_r7_enable_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        clk_enabled |-> (rd_data[STOP_HOST] == 1'b0 && rd_data[STOP_CARD] == 1'b0 && !cfg_invalid));
endmodule

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        card_clk, host_clk, cfg_invalid, clk_enabled;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    sdclk_gen i_sdclk_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_clk(card_clk), .host_clk(host_clk),
        .cfg_invalid(cfg_invalid), .clk_enabled(clk_enabled)
    );

    // ratio table: control word (stops clear) and expected period
    localparam int NV = 10;
    localparam logic [9:0] V_CFG [NV] = '{10'h001, 10'h005, 10'h009, 10'h00D, 10'h011,
                                          10'h000, 10'h004, 10'h008, 10'h00C, 10'h010};
    localparam int V_N [NV] = '{4, 8, 16, 32, 64, 2, 4, 8, 16, 32};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic lvl(input bit host);
        return host ? host_clk : card_clk;
    endfunction

    // measure one full high phase and the following low phase
    task automatic measure(input bit host, output int hi, output int lo);
        int t = 0;
        hi = 0; lo = 0;
        while (lvl(host) && t < 300) begin @(negedge clk); t++; end
        while (!lvl(host) && t < 300) begin @(negedge clk); t++; end
        while (lvl(host) && t < 300) begin @(negedge clk); t++; hi++; end
        while (!lvl(host) && t < 300) begin @(negedge clk); t++; lo++; end
        if (t >= 300) begin hi = -1; lo = -1; end
    endtask

    // count high samples over a window
    task automatic highs(input bit host, input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); if (lvl(host)) cnt++; end
    endtask

    // length of the next complete high phase, after skipping any in progress
    task automatic next_high(output int hi);
        hi = 0;
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        while (card_clk) begin @(negedge clk); hi++; end
    endtask

    initial begin
        int hi, lo, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(rd_data == 32'h301, "R2 reset word", rd_data, 32'h301);
        highs(0, 20, c); check(c == 0, "R2 card low after reset", c, 0);
        highs(1, 20, c); check(c == 0, "R2 host low after reset", c, 0);
        check(cfg_invalid == 1'b0, "R6 reset word valid", cfg_invalid, 0);
        check(clk_enabled == 1'b0, "R7 reset not enabled", clk_enabled, 0);

        // R1: readback keeps bits 9:0 only
        wr(32'hFFFF_F0A5);
        check(rd_data == 32'h0A5, "R1 readback masked", rd_data, 32'h0A5);

        // R3: table of ratios on both outputs
        for (int k = 0; k < NV; k++) begin
            wr({22'd0, V_CFG[k]});
            repeat (140) @(negedge clk);
            measure(0, hi, lo);
            check(hi == V_N[k]/2 && lo == V_N[k]/2, "R3 card phases", hi*100+lo, (V_N[k]/2)*101);
            measure(1, hi, lo);
            check(hi == V_N[k]/2 && lo == V_N[k]/2, "R3 host phases", hi*100+lo, (V_N[k]/2)*101);
        end

        // R7: enable status follows stop bits
        wr(32'h001);
        check(clk_enabled == 1'b1, "R7 enabled both run", clk_enabled, 1);
        wr(32'h101);
        check(clk_enabled == 1'b0, "R7 card stop disables", clk_enabled, 0);
        wr(32'h201);
        check(clk_enabled == 1'b0, "R7 host stop disables", clk_enabled, 0);

        // R4: card stopped, host runs
        wr(32'h105);
        repeat (140) @(negedge clk);
        highs(0, 200, c); check(c == 0, "R4 card held low", c, 0);
        measure(1, hi, lo); check(hi == 4 && lo == 4, "R4 host still runs", hi*100+lo, 404);

        // R5: host stopped, card runs
        wr(32'h205);
        repeat (140) @(negedge clk);
        highs(1, 200, c); check(c == 0, "R5 host held low", c, 0);
        measure(0, hi, lo); check(hi == 4 && lo == 4, "R5 card still runs", hi*100+lo, 404);

        // R6: unsupported codes
        wr(32'h014);
        check(cfg_invalid == 1'b1, "R6 pre code 5 flagged", cfg_invalid, 1);
        repeat (140) @(negedge clk);
        highs(0, 200, c); check(c == 0, "R6 card quiet", c, 0);
        highs(1, 200, c); check(c == 0, "R6 host quiet", c, 0);
        check(clk_enabled == 1'b0, "R7 invalid not enabled", clk_enabled, 0);
        wr(32'h003);
        check(cfg_invalid == 1'b1, "R6 final code 3 flagged", cfg_invalid, 1);
        wr(32'h002);
        check(cfg_invalid == 1'b1, "R6 final code 2 flagged", cfg_invalid, 1);
        check(rd_data == 32'h002, "R1 invalid word reads back", rd_data, 2);
        wr(32'h001);
        check(cfg_invalid == 1'b0, "R6 valid write clears", cfg_invalid, 0);
        repeat (140) @(negedge clk);
        measure(0, hi, lo); check(hi == 2 && lo == 2, "R6 recovers", hi*100+lo, 202);

        // R8: slow the ratio down in mid high phase (8 -> 32)
        wr(32'h005);
        repeat (140) @(negedge clk);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        wr(32'h00D);
        for (int p = 0; p < 3; p++) begin
            next_high(hi);
            check(hi == 4 || hi == 16, "R8 no runt on slow-down", hi, 16);
        end
        check(hi == 16, "R8 new ratio in force", hi, 16);

        // R8: speed up from the slowest to the fastest ratio (64 -> 2)
        wr(32'h011);
        repeat (140) @(negedge clk);
        while (card_clk) @(negedge clk);
        while (!card_clk) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(32'h000);
        for (int p = 0; p < 3; p++) begin
            next_high(hi);
            check(hi == 32 || hi == 1, "R8 no runt on speed-up", hi, 1);
        end
        check(hi == 1, "R8 fast ratio in force", hi, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule